// File: doc/BRIEF.md
# Hybrid Bimodal/Global Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps two component predictors. The first is a table of 2-bit saturating counters indexed by the low bits of the branch address. The second is a table of 2-bit saturating counters indexed by the low branch-address bits XORed with a shift register of recent branch outcomes. A third table of 2-bit counters, also indexed by branch address, selects per branch which component supplies the final answer.

The front end presents a branch address on the predict port. In the same cycle it gets back the final direction, the component chosen, and both component predictions. When the branch resolves, the pipeline presents the address, the real outcome and the two component predictions it used on the update port. On the next clock edge the block trains all three counters and shifts the outcome into the history. The update port always forms the global index from the history as it stands before that shift.

The default configuration has 1K bimodal entries, 1K selector entries, a 12-bit history and a 4K-entry global table. Setting `GLB_W` to 14 gives a 16K-entry global table.

Top module: `hybrid_branch_predictor`

## Requirements
- R1: After reset, every counter holds 01 (weakly not-taken) and the history is all zeros. Every address therefore reads predTaken=0, predUseGlobal=0, predBimTaken=0 and predGlbTaken=0.
- R2: predBimTaken is bit 1 (the MSB) of the bimodal counter at index predPc[BIM_W-1:0].
- R3: predGlbTaken is the MSB of the global counter at index predPc[GLB_W-1:0] XOR the history zero-extended to GLB_W bits.
- R4: Each update shifts the history left by one and puts updTaken into bit 0, so the history holds the last HIST_W outcomes with the newest at bit 0.
- R5: On update, the bimodal counter at updPc[BIM_W-1:0] and the global counter at the update-side global index both count up when updTaken=1 and down when updTaken=0. They saturate at 3 and at 0.
- R6: On update, the selector counter at updPc[SEL_W-1:0] changes only when exactly one of updBimTaken and updGlbTaken equals updTaken. It counts up (toward global) when the global prediction was the correct one and down when the bimodal prediction was, saturating at 3 and 0. Its MSB drives predUseGlobal (1 means global).
- R7: While updValid=0, no counter and no history bit changes, whatever the other update inputs are.
- R8: predTaken equals predGlbTaken when predUseGlobal=1 and equals predBimTaken otherwise.
- R9: The update-side global index is updPc[GLB_W-1:0] XOR the history value held before that update's shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| predPc | input | PC_W | Address of the branch to predict |
| predTaken | output | 1 | Final predicted direction |
| predUseGlobal | output | 1 | 1 when the global component was selected |
| predBimTaken | output | 1 | Bimodal component prediction |
| predGlbTaken | output | 1 | Global component prediction |
| updValid | input | 1 | Update strobe for a resolved branch |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Actual outcome of the resolved branch |
| updBimTaken | input | 1 | Bimodal prediction that was used for this branch |
| updGlbTaken | input | 1 | Global prediction that was used for this branch |

## Verification
A wrong counter stays hidden until the same index is read again. When it is read, predBimTaken, predGlbTaken or predUseGlobal shows the error in that same cycle. A wrong history bit is worse, because it moves the global index for every address until the bit has shifted out. That takes up to twelve updates. For this reason the bench predicts every cycle from a behavioural model and uses a small address range, so training and reads keep colliding on the same entries. Directed runs push one entry past both saturation limits, hold the update strobe low while its other inputs toggle, and cycle the selector through its cases of one component correct, both correct and neither correct.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CtrReset = 2'b01;

  typedef struct packed {
    logic bimUp;
    logic bimDown;
    logic glbUp;
    logic glbDown;
    logic selUp;
    logic selDown;
    logic histShift;
    logic histBit;
  } strobe_t;
endpackage

// File: rtl/hbp_sat_table.sv
module hbp_sat_table
  import hbp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             rdTaken,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             up,
  input  logic             down
);
  localparam int Depth = 1 << IDX_W;

  ctr_t cnt [Depth];
  ctr_t wrCur;

  assign wrCur   = cnt[wrIdx];
  assign rdTaken = cnt[rdIdx][1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < Depth; i++) cnt[i] <= CtrReset;
    end else if (up && wrCur != 2'b11) begin
      cnt[wrIdx] <= wrCur + 2'd1;
    end else if (down && wrCur != 2'b00) begin
      cnt[wrIdx] <= wrCur - 2'd1;
    end
  end
endmodule

// File: rtl/hbp_ctrl.sv
module hbp_ctrl
  import hbp_pkg::*;
(
  input  logic    updValid,
  input  logic    updTaken,
  input  logic    updBimTaken,
  input  logic    updGlbTaken,
  output strobe_t strobes
);
  logic bimRight;
  logic glbRight;

  assign bimRight = (updBimTaken == updTaken);
  assign glbRight = (updGlbTaken == updTaken);

  always_comb begin
    strobes           = '0;
    strobes.histBit   = updTaken;
    if (updValid) begin
      strobes.bimUp     = updTaken;
      strobes.bimDown   = !updTaken;
      strobes.glbUp     = updTaken;
      strobes.glbDown   = !updTaken;
      strobes.selUp     = glbRight && !bimRight;
      strobes.selDown   = bimRight && !glbRight;
      strobes.histShift = 1'b1;
    end
  end
endmodule

// File: rtl/hbp_datapath.sv
module hbp_datapath
  import hbp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int BIM_W  = 10,
  parameter int SEL_W  = 10,
  parameter int GLB_W  = 12,
  parameter int HIST_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   predPc,
  input  logic [PC_W-1:0]   updPc,
  input  strobe_t           strobes,
  output logic              bimTaken,
  output logic              glbTaken,
  output logic              selGlobal,
  output logic [HIST_W-1:0] histQ
);
  logic [GLB_W-1:0] histExt;
  logic [GLB_W-1:0] glbRdIdx;
  logic [GLB_W-1:0] glbWrIdx;

  always_comb begin
    histExt             = '0;
    histExt[HIST_W-1:0] = histQ;
  end

  assign glbRdIdx = predPc[GLB_W-1:0] ^ histExt;
  assign glbWrIdx = updPc[GLB_W-1:0] ^ histExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 histQ <= '0;
    else if (strobes.histShift) histQ <= {histQ[HIST_W-2:0], strobes.histBit};
  end

  hbp_sat_table #(.IDX_W(BIM_W)) uBim (
    .clk(clk), .rstN(rstN),
    .rdIdx(predPc[BIM_W-1:0]), .rdTaken(bimTaken),
    .wrIdx(updPc[BIM_W-1:0]), .up(strobes.bimUp), .down(strobes.bimDown)
  );

  hbp_sat_table #(.IDX_W(GLB_W)) uGlb (
    .clk(clk), .rstN(rstN),
    .rdIdx(glbRdIdx), .rdTaken(glbTaken),
    .wrIdx(glbWrIdx), .up(strobes.glbUp), .down(strobes.glbDown)
  );

  hbp_sat_table #(.IDX_W(SEL_W)) uSel (
    .clk(clk), .rstN(rstN),
    .rdIdx(predPc[SEL_W-1:0]), .rdTaken(selGlobal),
    .wrIdx(updPc[SEL_W-1:0]), .up(strobes.selUp), .down(strobes.selDown)
  );
endmodule

// File: rtl/hybrid_branch_predictor.sv
module hybrid_branch_predictor
  import hbp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int BIM_W  = 10,
  parameter int SEL_W  = 10,
  parameter int GLB_W  = 12,
  parameter int HIST_W = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] predPc,
  output logic            predTaken,
  output logic            predUseGlobal,
  output logic            predBimTaken,
  output logic            predGlbTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic            updBimTaken,
  input  logic            updGlbTaken
);
  strobe_t           strobes;
  logic [HIST_W-1:0] histQ;

  hbp_ctrl uCtrl (
    .updValid(updValid), .updTaken(updTaken),
    .updBimTaken(updBimTaken), .updGlbTaken(updGlbTaken),
    .strobes(strobes)
  );

  hbp_datapath #(
    .PC_W(PC_W), .BIM_W(BIM_W), .SEL_W(SEL_W), .GLB_W(GLB_W), .HIST_W(HIST_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .predPc(predPc), .updPc(updPc), .strobes(strobes),
    .bimTaken(predBimTaken), .glbTaken(predGlbTaken),
    .selGlobal(predUseGlobal), .histQ(histQ)
  );

  assign predTaken = predUseGlobal ? predGlbTaken : predBimTaken;
endmodule

// File: rtl/hbp_checker.sv
module hbp_checker #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [PC_W-1:0]   predPc,
  input logic              predUseGlobal,
  input logic              predBimTaken,
  input logic              predGlbTaken,
  input logic              updValid,
  input logic [PC_W-1:0]   updPc,
  input logic              updTaken,
  input logic              updBimTaken,
  input logic              updGlbTaken,
  input logic [HIST_W-1:0] histQ
);
  // R4: newest outcome enters at bit 0, older bits move up
  p_hist_shift_r4: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> (histQ[0] == $past(updTaken)) &&
                 (histQ[HIST_W-1:1] == $past(histQ[HIST_W-2:0])));

  // R7: no update leaves the history alone
  p_hist_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(histQ));

  // R7: no update and same address keeps every prediction
  p_pred_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> ($stable(predPc) -> ($stable(predBimTaken) &&
                  $stable(predGlbTaken) && $stable(predUseGlobal))));

  // R5: a taken-leaning bimodal counter trained taken stays taken
  p_bim_sat_hi_r5: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updTaken && predBimTaken && updPc == predPc) |=>
      (predPc != $past(predPc) || predBimTaken));

  // R5: a not-taken-leaning bimodal counter trained not-taken stays not-taken
  p_bim_sat_lo_r5: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updTaken && !predBimTaken && updPc == predPc) |=>
      (predPc != $past(predPc) || !predBimTaken));

  // R6: selector holds when both or neither component was right
  p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updBimTaken == updGlbTaken && updPc == predPc) |=>
      (predPc != $past(predPc) || predUseGlobal == $past(predUseGlobal)));
endmodule

bind hybrid_branch_predictor hbp_checker #(.PC_W(PC_W), .HIST_W(HIST_W)) uChk (
  .clk(clk), .rstN(rstN), .predPc(predPc), .predUseGlobal(predUseGlobal),
  .predBimTaken(predBimTaken), .predGlbTaken(predGlbTaken),
  .updValid(updValid), .updPc(updPc), .updTaken(updTaken),
  .updBimTaken(updBimTaken), .updGlbTaken(updGlbTaken), .histQ(histQ)
);

// File: tb/hybrid_branch_predictor_test.sv
module hybrid_branch_predictor_test;
  localparam int PC_W   = 32;
  localparam int BIM_W  = 10;
  localparam int SEL_W  = 10;
  localparam int GLB_W  = 12;
  localparam int HIST_W = 12;
  localparam int BimMask  = (1 << BIM_W) - 1;
  localparam int SelMask  = (1 << SEL_W) - 1;
  localparam int GlbMask  = (1 << GLB_W) - 1;
  localparam int HistMask = (1 << HIST_W) - 1;

  logic            clk = 1'b0;
  logic            rstN;
  logic [PC_W-1:0] predPc;
  logic            predTaken, predUseGlobal, predBimTaken, predGlbTaken;
  logic            updValid;
  logic [PC_W-1:0] updPc;
  logic            updTaken, updBimTaken, updGlbTaken;

  always #5 clk = ~clk;

  hybrid_branch_predictor #(
    .PC_W(PC_W), .BIM_W(BIM_W), .SEL_W(SEL_W), .GLB_W(GLB_W), .HIST_W(HIST_W)
  ) uut (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predTaken(predTaken),
    .predUseGlobal(predUseGlobal), .predBimTaken(predBimTaken),
    .predGlbTaken(predGlbTaken), .updValid(updValid), .updPc(updPc),
    .updTaken(updTaken), .updBimTaken(updBimTaken), .updGlbTaken(updGlbTaken)
  );

  int bimM [1 << BIM_W];
  int selM [1 << SEL_W];
  int glbM [1 << GLB_W];
  int histM;
  int nRun  = 0;
  int nFail = 0;

  function automatic int lowBits(logic [PC_W-1:0] pc, int mask);
    return int'(pc[30:0]) & mask;
  endfunction

  function automatic int satStep(int c, bit up);
    if (up)  return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction

  task automatic modelReset();
    foreach (bimM[i]) bimM[i] = 1;
    foreach (selM[i]) selM[i] = 1;
    foreach (glbM[i]) glbM[i] = 1;
    histM = 0;
  endtask

  task automatic modelUpdate(logic [PC_W-1:0] pc, bit t, bit ub, bit ug);
    int bi = lowBits(pc, BimMask);
    int si = lowBits(pc, SelMask);
    int gi = (lowBits(pc, GlbMask) ^ histM) & GlbMask;  // R9: pre-shift history
    bit bOk = (ub == t);
    bit gOk = (ug == t);
    bimM[bi] = satStep(bimM[bi], t);
    glbM[gi] = satStep(glbM[gi], t);
    if (bOk != gOk) selM[si] = satStep(selM[si], gOk);
    histM = ((histM << 1) | int'(t)) & HistMask;
  endtask

  task automatic chk(string tag, string what, int got, int exp);
    nRun++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic bit expBim(logic [PC_W-1:0] pc);
    return bimM[lowBits(pc, BimMask)] >= 2;
  endfunction

  function automatic bit expGlb(logic [PC_W-1:0] pc);
    return glbM[(lowBits(pc, GlbMask) ^ histM) & GlbMask] >= 2;
  endfunction

  function automatic bit expSel(logic [PC_W-1:0] pc);
    return selM[lowBits(pc, SelMask)] >= 2;
  endfunction

  task automatic compare(string tag);
    bit eb = expBim(predPc);
    bit eg = expGlb(predPc);
    bit es = expSel(predPc);
    chk(tag, "predBimTaken", int'(predBimTaken), int'(eb));
    chk(tag, "predGlbTaken", int'(predGlbTaken), int'(eg));
    chk(tag, "predUseGlobal", int'(predUseGlobal), int'(es));
    chk(tag, "predTaken", int'(predTaken), int'(es ? eg : eb));
  endtask

  task automatic step(string tag, logic [PC_W-1:0] pPc, bit v,
                      logic [PC_W-1:0] uPc, bit t, bit ub, bit ug);
    predPc = pPc; updValid = v; updPc = uPc;
    updTaken = t; updBimTaken = ub; updGlbTaken = ug;
    #1 compare(tag);
    @(posedge clk);
    if (v) modelUpdate(uPc, t, ub, ug);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; predPc = '0; updValid = 1'b0; updPc = '0;
    updTaken = 1'b0; updBimTaken = 1'b0; updGlbTaken = 1'b0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state seen at several addresses
    foreach (bimM[i]) if (i < 8) step("R1", PC_W'(i * 97), 1'b0, '0, 1'b0, 1'b0, 1'b0);

    // R5: one branch driven past both saturation limits
    for (int k = 0; k < 6; k++)
      step("R5", 32'h40, 1'b1, 32'h40, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 6; k++)
      step("R5", 32'h40, 1'b1, 32'h40, 1'b0, 1'b0, 1'b0);

    // R6: global right / bimodal wrong flips the selector, then reverse
    for (int k = 0; k < 4; k++)
      step("R6", 32'h84, 1'b1, 32'h84, 1'b1, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++)
      step("R6", 32'h84, 1'b1, 32'h84, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 3; k++)
      step("R6", 32'h84, 1'b1, 32'h84, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++)
      step("R6", 32'h84, 1'b1, 32'h84, 1'b0, 1'b0, 1'b1);

    // R4 and R9: history-driven global indexing, fixed address, pattern outcomes
    for (int k = 0; k < 60; k++)
      step("R4/R9", 32'h123, 1'b1, 32'h123, bit'((k % 3) != 0), 1'b0, 1'b1);

    // R7: update strobe low while other update inputs toggle
    for (int k = 0; k < 40; k++)
      step("R7", PC_W'($urandom % 64), 1'b0, PC_W'($urandom % 64),
           bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2));

    // R2/R3/R8: random traffic over a small address range, predictions fed back
    for (int k = 0; k < 3000; k++) begin
      logic [PC_W-1:0] pa = PC_W'($urandom % 48);
      logic [PC_W-1:0] ua = PC_W'($urandom % 48);
      bit eb = expBim(ua);
      bit eg = expGlb(ua);
      step("R2/R3/R8", pa, bit'($urandom % 4 != 0), ua, bit'($urandom % 2), eb, eg);
    end

    // R6: random component correctness on aliasing high addresses
    for (int k = 0; k < 1500; k++) begin
      logic [PC_W-1:0] ua = {$urandom} & 32'hFFFF_F01F;
      step("R6", ua, 1'b1, ua, bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2));
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule